// File: doc/BRIEF.md
# Shared Serial-Flash Bus Arbiter

This block sits between one local SPI command engine and the wires of a serial flash device that a second, external master also uses. It keeps track of who owns the shared clock, data-out and chip-select lines. When the local side does not own them, it holds its drivers in high impedance. It also spaces out every change of owner so that the two masters never drive the lines at the same time.

The peer master asks for the bus by pulling a private, active-low arbitration line low. The flash never sees this line. The local side answers only at a safe point:

- A plain read ends at its chip-select rise.
- A program or erase operation stays atomic through every later chip-select pulse. It ends only when the local engine reports a status poll with the busy bit clear.

After that, the local drivers are switched off and the bus is left idle for a fixed turnaround. Only then is ownership passed on.

Simultaneous requests go to the local engine. The peer is always served at the next handoff.

Top module: `spi_share_arb`

## Requirements
- R1: While reset is applied and just after it, `grant_o` and `peer_gnt_o` are low, all three drive enables are low and `cs_n_o` is 1.
- R2: Whenever `grant_o` is low, `sck_oe_o`, `mosi_oe_o` and `cs_n_oe_o` are 0, `cs_n_o` is 1, `sck_o`/`mosi_o` are 0 and `eng_miso_o` is 0, whatever the engine drives.
- R3: While `grant_o` is high, all three enables are 1, `sck_o`, `mosi_o` and `cs_n_o` equal the engine's values, and `eng_miso_o` equals `miso_i`.
- R4: With the bus free and the arbitration line high, raising `req_i` sets `grant_o` after one clock edge.
- R5: A transaction whose `eng_pe_i` was 0 at its chip-select fall ends ownership. `grant_o` drops on the edge that follows the cycle in which `eng_cs_n_i` is seen high again.
- R6: A transaction whose `eng_pe_i` was 1 at its chip-select fall keeps `grant_o` high across later chip-select rises, a dropped `req_i` and polls reporting `poll_busy_i`=1. `grant_o` drops on the edge after `poll_done_i`=1 with `poll_busy_i`=0 while `eng_cs_n_i` is 1.
- R7: `arb_n_i` held low while the bus is free raises `peer_gnt_o` three edges later, after two synchroniser stages. While `peer_gnt_o` is high, `req_i` is not granted. `peer_gnt_o` drops three edges after the line returns high.
- R8: Between one owner losing the bus and the next gaining it, `grant_o` and `peer_gnt_o` are both low for at least TURN_CYC (default 2) cycles.
- R9: If the local request and a synchronised peer request are present in the same free cycle, the local side wins. At its release the peer is granted next, even while `req_i` stays high.
- R10: If `req_i` drops while the local side owns the bus with no transaction open and no program/erase pending, `grant_o` drops on the next edge.
- R11: `grant_o` and `peer_gnt_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Local engine wants the bus |
| grant_o | output | 1 | Local engine owns the bus |
| eng_pe_i | input | 1 | Sampled at chip-select fall: 1 = program/erase command |
| eng_sck_i | input | 1 | Engine serial clock value |
| eng_mosi_i | input | 1 | Engine data-out value |
| eng_cs_n_i | input | 1 | Engine chip select, active low |
| eng_miso_o | output | 1 | Flash data returned to engine (0 when not owner) |
| poll_done_i | input | 1 | Engine finished a status-register read |
| poll_busy_i | input | 1 | Busy bit of that status read |
| arb_n_i | input | 1 | Peer arbitration line, low = peer requests/holds bus |
| peer_gnt_o | output | 1 | Local side released the bus to the peer |
| sck_o | output | 1 | Shared clock pin value |
| sck_oe_o | output | 1 | Shared clock drive enable |
| mosi_o | output | 1 | Shared data-out pin value |
| mosi_oe_o | output | 1 | Shared data-out drive enable |
| cs_n_o | output | 1 | Shared chip-select pin value |
| cs_n_oe_o | output | 1 | Shared chip-select drive enable |
| miso_i | input | 1 | Shared data-in pin |

## Verification
The hardest situation to reach is a true tie. The local request and the peer request must meet in the same free cycle, and the peer must still be waiting when the local read finishes. Only then does the fairness rule override a local request that is still high. The bench pulls the arbitration line low first. It waits exactly the two synchroniser edges, and only in the cycle where the synchronised request becomes visible does it raise `req_i`. It then runs a short read and checks that the next owner is the peer. Program/erase atomicity is reached by interleaving chip-select rises, a dropped request and a busy poll before the clean poll.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LOCAL = 2'd1,
    OWN_TURN  = 2'd2,
    OWN_PEER  = 2'd3
  } own_e;

  localparam int unsigned PIN_CNT = 3;
  // pin order inside vectors: [0]=clock, [1]=data out, [2]=chip select
  localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/spi_arb_sync.sv
module spi_arb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{IDLE_LV}};
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/spi_arb_txn.sv
// Tracks the local transaction in flight and decides when ownership may end.
module spi_arb_txn (
  input  logic clk,
  input  logic rst_n,
  input  logic owned_i,
  input  logic req_i,
  input  logic cs_n_i,
  input  logic pe_i,
  input  logic poll_done_i,
  input  logic poll_busy_i,
  output logic pe_pend_o,
  output logic release_o
);
  logic cs_q, cs_d;
  logic pend_q, pend_d;
  logic cs_fall;

  assign cs_fall = owned_i && cs_q && !cs_n_i;

  always_comb begin
    release_o = 1'b0;
    if (owned_i && cs_n_i) begin
      if (pend_q) release_o = poll_done_i && !poll_busy_i;   // R6
      else        release_o = !cs_q || !req_i;               // R5, R10
    end
  end

  always_comb begin
    cs_d   = owned_i ? cs_n_i : 1'b1;
    pend_d = pend_q;
    if (cs_fall && pe_i) pend_d = 1'b1;
    if (release_o)       pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      pend_q <= pend_d;
    end
  end

  assign pe_pend_o = pend_q;
endmodule

// File: rtl/spi_arb_fsm.sv
module spi_arb_fsm
  import spi_arb_pkg::*;
#(
  parameter int unsigned TURN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic peer_req_i,
  input  logic release_i,
  output logic grant_o,
  output logic peer_gnt_o
);
  localparam int unsigned CW = $clog2(TURN_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TURN_CYC - 1);

  own_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_loc_q, last_loc_d;

  always_comb begin
    st_d       = st_q;
    cnt_d      = '0;
    last_loc_d = last_loc_q;
    unique case (st_q)
      OWN_FREE: begin
        if (req_i)           st_d = OWN_LOCAL;   // R9 local wins ties
        else if (peer_req_i) st_d = OWN_PEER;
      end
      OWN_LOCAL: begin
        if (release_i) begin
          st_d       = OWN_TURN;
          last_loc_d = 1'b1;
        end
      end
      OWN_PEER: begin
        if (!peer_req_i) begin                   // R7
          st_d       = OWN_TURN;
          last_loc_d = 1'b0;
        end
      end
      OWN_TURN: begin
        if (cnt_q == CNT_LAST) begin             // R8
          if (peer_req_i && (last_loc_q || !req_i)) st_d = OWN_PEER;
          else if (req_i)                           st_d = OWN_LOCAL;
          else                                      st_d = OWN_FREE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= OWN_FREE;
      cnt_q      <= '0;
      last_loc_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      last_loc_q <= last_loc_d;
    end
  end

  assign grant_o    = (st_q == OWN_LOCAL);
  assign peer_gnt_o = (st_q == OWN_PEER);
endmodule

// File: rtl/spi_arb_pads.sv
module spi_arb_pads
  import spi_arb_pkg::*;
(
  input  logic               drive_i,
  input  logic [PIN_CNT-1:0] val_i,
  output logic [PIN_CNT-1:0] pin_o,
  output logic [PIN_CNT-1:0] oe_o
);
  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    assign pin_o[i] = drive_i ? val_i[i] : PIN_IDLE[i];   // R2, R3
    assign oe_o[i]  = drive_i;
  end
endmodule

// File: rtl/spi_share_arb.sv
module spi_share_arb
  import spi_arb_pkg::*;
#(
  parameter int unsigned TURN_CYC   = 2,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic grant_o,
  input  logic eng_pe_i,
  input  logic eng_sck_i,
  input  logic eng_mosi_i,
  input  logic eng_cs_n_i,
  output logic eng_miso_o,
  input  logic poll_done_i,
  input  logic poll_busy_i,
  input  logic arb_n_i,
  output logic peer_gnt_o,
  output logic sck_o,
  output logic sck_oe_o,
  output logic mosi_o,
  output logic mosi_oe_o,
  output logic cs_n_o,
  output logic cs_n_oe_o,
  input  logic miso_i
);
  logic [RST_STAGES-1:0] rst_sh_q;
  logic                  rst_int_n;
  logic                  arb_sync;
  logic                  peer_req;
  logic                  release_ev;
  logic                  pe_pend;
  logic [PIN_CNT-1:0]    pin_val, pin_out, pin_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[RST_STAGES-1];

  spi_arb_sync #(.STAGES(SYNC_STG), .IDLE_LV(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (arb_n_i),
    .q_o   (arb_sync)
  );
  assign peer_req = !arb_sync;

  spi_arb_txn u_txn (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .owned_i     (grant_o),
    .req_i       (req_i),
    .cs_n_i      (eng_cs_n_i),
    .pe_i        (eng_pe_i),
    .poll_done_i (poll_done_i),
    .poll_busy_i (poll_busy_i),
    .pe_pend_o   (pe_pend),
    .release_o   (release_ev)
  );

  spi_arb_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .peer_req_i (peer_req),
    .release_i  (release_ev),
    .grant_o    (grant_o),
    .peer_gnt_o (peer_gnt_o)
  );

  assign pin_val = {eng_cs_n_i, eng_mosi_i, eng_sck_i};

  spi_arb_pads u_pads (
    .drive_i (grant_o),
    .val_i   (pin_val),
    .pin_o   (pin_out),
    .oe_o    (pin_oe)
  );

  assign sck_o      = pin_out[0];
  assign mosi_o     = pin_out[1];
  assign cs_n_o     = pin_out[2];
  assign sck_oe_o   = pin_oe[0];
  assign mosi_oe_o  = pin_oe[1];
  assign cs_n_oe_o  = pin_oe[2];
  assign eng_miso_o = grant_o & miso_i;
endmodule

// File: rtl/spi_share_arb_chk.sv
module spi_share_arb_chk #(
  parameter int unsigned TURN_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic peer_gnt,
  input logic pe_pend,
  input logic cs_n,
  input logic sck_oe,
  input logic mosi_oe,
  input logic cs_oe
);
  localparam int unsigned CW = $clog2(TURN_CYC + 1);
  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    quiet_q <= CW'(TURN_CYC);
    else if (grant || peer_gnt)    quiet_q <= '0;
    else if (quiet_q < CW'(TURN_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n) !(grant && peer_gnt)); // R11
  AST_OFF_WHEN_NOT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> (cs_n && !sck_oe && !mosi_oe && !cs_oe)); // R2
  AST_PE_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n) pe_pend |-> grant); // R6
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant) || $rose(peer_gnt)) |-> (quiet_q >= CW'(TURN_CYC))); // R8
  AST_PEER_NOT_STRAIGHT_TO_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(peer_gnt) |-> !grant); // R8
endmodule

bind spi_share_arb spi_share_arb_chk #(.TURN_CYC(TURN_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant_o),
  .peer_gnt (peer_gnt_o),
  .pe_pend  (pe_pend),
  .cs_n     (cs_n_o),
  .sck_oe   (sck_oe_o),
  .mosi_oe  (mosi_oe_o),
  .cs_oe    (cs_n_oe_o)
);

// File: tb/test_spi_share_arb.sv
`timescale 1ns/1ps
module test_spi_share_arb;
  logic clk = 1'b0;
  logic rst_n;
  logic req_i, eng_pe_i, eng_sck_i, eng_mosi_i, eng_cs_n_i;
  logic poll_done_i, poll_busy_i, arb_n_i, miso_i;
  logic grant_o, eng_miso_o, peer_gnt_o;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, cs_n_o, cs_n_oe_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic  g;
    logic  pg;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;   // 50 MHz

  spi_share_arb i_spi_share_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .grant_o(grant_o),
    .eng_pe_i(eng_pe_i), .eng_sck_i(eng_sck_i), .eng_mosi_i(eng_mosi_i),
    .eng_cs_n_i(eng_cs_n_i), .eng_miso_o(eng_miso_o),
    .poll_done_i(poll_done_i), .poll_busy_i(poll_busy_i),
    .arb_n_i(arb_n_i), .peer_gnt_o(peer_gnt_o),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .cs_n_o(cs_n_o), .cs_n_oe_o(cs_n_oe_o), .miso_i(miso_i)
  );

  // monitor: one expectation consumed per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      tests++;
      if (grant_o !== e.g || peer_gnt_o !== e.pg) begin
        fails++;
        $display("FAIL %s: grant/peer actual=%b%b expected=%b%b", e.tag, grant_o, peer_gnt_o, e.g, e.pg);
      end
    end
  end

  task automatic cyc(input logic g, input logic pg, input string tag);
    exp_q.push_back('{g, pg, tag});
    @(negedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  // pins = {sck_o, mosi_o, cs_n_o, sck_oe_o, mosi_oe_o, cs_n_oe_o, eng_miso_o}
  task automatic chk_pins(input logic [6:0] expv, input string tag);
    logic [6:0] act;
    #1;
    act = {sck_o, mosi_o, cs_n_o, sck_oe_o, mosi_oe_o, cs_n_oe_o, eng_miso_o};
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: pins actual=%b expected=%b", tag, act, expv);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; eng_pe_i = 1'b0; eng_sck_i = 1'b0;
    eng_mosi_i = 1'b0; eng_cs_n_i = 1'b1; poll_done_i = 1'b0;
    poll_busy_i = 1'b0; arb_n_i = 1'b1; miso_i = 1'b0;
    idle(3);
    chk_pins(7'b0010000, "R1 in reset");
    rst_n = 1'b1;
    idle(4);
    cyc(1'b0, 1'b0, "R1 after reset");
    chk_pins(7'b0010000, "R1 pins after reset");

    // read transaction, pass-through, release, turnaround, idle drop
    req_i = 1'b1;
    cyc(1'b1, 1'b0, "R4 grant");
    eng_sck_i = 1'b1; eng_mosi_i = 1'b1; eng_cs_n_i = 1'b0; miso_i = 1'b1;
    chk_pins(7'b1101111, "R3 pass-through");
    cyc(1'b1, 1'b0, "R5 read open");
    eng_cs_n_i = 1'b1;
    cyc(1'b0, 1'b0, "R5 read release");
    chk_pins(7'b0010000, "R2 drivers off");
    eng_sck_i = 1'b0; eng_mosi_i = 1'b0; miso_i = 1'b0;
    cyc(1'b0, 1'b0, "R8 gap");
    cyc(1'b1, 1'b0, "R8 regrant after gap");
    req_i = 1'b0;
    cyc(1'b0, 1'b0, "R10 idle drop");
    idle(4);

    // program/erase held until clean poll
    req_i = 1'b1;
    cyc(1'b1, 1'b0, "R4 grant");
    eng_cs_n_i = 1'b0; eng_pe_i = 1'b1;
    cyc(1'b1, 1'b0, "R6 pe open");
    eng_cs_n_i = 1'b1; eng_pe_i = 1'b0;
    cyc(1'b1, 1'b0, "R6 cs rise keeps");
    req_i = 1'b0;
    cyc(1'b1, 1'b0, "R6 req drop ignored");
    eng_cs_n_i = 1'b0;
    cyc(1'b1, 1'b0, "R6 poll read");
    eng_cs_n_i = 1'b1;
    cyc(1'b1, 1'b0, "R6 poll end");
    poll_done_i = 1'b1; poll_busy_i = 1'b1;
    cyc(1'b1, 1'b0, "R6 busy poll");
    poll_done_i = 1'b0;
    cyc(1'b1, 1'b0, "R6 still held");
    poll_done_i = 1'b1; poll_busy_i = 1'b0;
    cyc(1'b0, 1'b0, "R6 clean poll release");
    poll_done_i = 1'b0;
    idle(4);

    // peer ownership
    arb_n_i = 1'b0;
    cyc(1'b0, 1'b0, "R7 sync 1");
    cyc(1'b0, 1'b0, "R7 sync 2");
    cyc(1'b0, 1'b1, "R7 peer granted");
    eng_sck_i = 1'b1;
    chk_pins(7'b0010000, "R2 peer owns");
    eng_sck_i = 1'b0;
    req_i = 1'b1;
    cyc(1'b0, 1'b1, "R7 local blocked");
    cyc(1'b0, 1'b1, "R7 local blocked");
    arb_n_i = 1'b1;
    cyc(1'b0, 1'b1, "R7 release sync 1");
    cyc(1'b0, 1'b1, "R7 release sync 2");
    cyc(1'b0, 1'b0, "R7 peer dropped");
    cyc(1'b0, 1'b0, "R8 gap");
    cyc(1'b1, 1'b0, "R8 local after gap");
    req_i = 1'b0;
    cyc(1'b0, 1'b0, "R10 idle drop");
    idle(4);

    // tie and fairness
    arb_n_i = 1'b0;
    cyc(1'b0, 1'b0, "R9 sync 1");
    cyc(1'b0, 1'b0, "R9 sync 2");
    req_i = 1'b1;
    cyc(1'b1, 1'b0, "R9 tie local wins");
    eng_cs_n_i = 1'b0;
    cyc(1'b1, 1'b0, "R9 read open");
    eng_cs_n_i = 1'b1;
    cyc(1'b0, 1'b0, "R5 release");
    cyc(1'b0, 1'b0, "R8 gap");
    cyc(1'b0, 1'b1, "R9 peer served next");
    arb_n_i = 1'b1;
    cyc(1'b0, 1'b1, "R9 peer hold 1");
    cyc(1'b0, 1'b1, "R9 peer hold 2");
    cyc(1'b0, 1'b0, "R9 peer dropped");
    cyc(1'b0, 1'b0, "R8 gap");
    cyc(1'b1, 1'b0, "R9 local after peer");
    req_i = 1'b0;
    cyc(1'b0, 1'b0, "R10 idle drop");
    idle(3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule